// File: doc/BRIEF.md
# Doubleword/Word Shift Unit

This block performs every integer shift needed by a 64-bit datapath that also supports 32-bit word arithmetic. A 4-bit operation code picks one of fifteen variants. Each variant is defined by three choices: the width (word or doubleword), the direction and fill (left, logical right or arithmetic right), and the source of the shift amount (a 5-bit immediate, the low bits of a register value, or the immediate plus 32).

Word variants see only bits 31..0 of the operand. Their 32-bit result is always widened to 64 bits by copying bit 31, and this includes logical right shifts. Doubleword variants work on the full 64 bits.

The shift itself is combinational. A single result register, cleared by a synchronous active-low reset, presents the value one clock after the inputs are applied. Decode, register access and hazard handling are done elsewhere. The integrator feeds the low six bits of the shift-amount register into `reg_sa_i`.

Top module: `shift_unit`

## Requirements
- R1: Word left shifts (codes 0 and 3) shift operand bits 31..0 left and fill with zeros. Result bits 63..32 are copies of result bit 31. Operand bits 63..32 have no effect.
- R2: Word logical right shifts (codes 1 and 4) shift operand bits 31..0 right and fill with zeros. The 32-bit value is then sign-extended from bit 31, so a zero amount with operand bit 31 set gives a negative result.
- R3: Word arithmetic right shifts (codes 2 and 5) fill with operand bit 31 and ignore operand bits 63..32. The result is sign-extended from bit 31.
- R4: Word register-amount variants (codes 3, 4 and 5) use only bit 4..0 of `reg_sa_i`, so bit 5 has no effect.
- R5: Doubleword register-amount variants (codes 9, 10 and 11) use all six bits of `reg_sa_i`, giving amounts 0..63.
- R6: The high-range immediate variants (codes 12, 13 and 14) shift by 32 plus `imm_sa_i`, giving amounts 32..63.
- R7: Doubleword arithmetic right shifts (codes 8, 11 and 14) fill with operand bit 63. Doubleword logical right shifts (codes 7, 10 and 13) fill with zeros. Doubleword left shifts (codes 6, 9 and 12) fill with zeros.
- R8: A shift amount of zero returns the operand unchanged for doubleword forms. For word forms it returns operand bits 31..0 sign-extended.
- R9: Code layout:
  - 0..2: word immediate (left, logical right, arithmetic right).
  - 3..5: word register amount, in the same order.
  - 6..8: doubleword immediate, in the same order.
  - 9..11: doubleword register amount, in the same order.
  - 12..14: doubleword immediate plus 32, in the same order.
  - Code 15 produces an all-zero result.
- R10: `result_o` shows the result for the inputs present at the previous rising clock edge. While `rst_n` is low at a rising edge, `result_o` becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code (see R9) |
| operand_i | input | 64 | Value to be shifted |
| imm_sa_i | input | 5 | Immediate shift amount |
| reg_sa_i | input | 6 | Low six bits of the shift-amount register |
| result_o | output | 64 | Registered shift result |

## Verification
The bench targets the following corner cases:
- **Logical right word shift with bit 31 set, zero amount.** A unit that zero-extends word results would return a positive value here instead of a negative one.
- **Word register amount with bit 5 set.** A unit that reused the doubleword mask would shift by 32 or more and clear the word, where the correct result is a pass-through or a short shift.
- **High-range variants at both ends (32 and 63).** An adder that drops the carry into bit 5 would shift by the bare immediate.
- **Garbage in operand bits 63..32 for word arithmetic shifts.** A sign taken from bit 63 instead of bit 31 would fill with the wrong value.
- **Exhaustive sweep of every code at every amount.** This catches stage or reversal wiring errors in the barrel.

// File: rtl/shift_unit_pkg.sv
// Package: shared widths, the operation code set and the decoded control
// record for the shift unit. Assumes a 64-bit datapath with 32-bit words.
package shift_unit_pkg;

    localparam int XLEN   = 64;
    localparam int HALF   = 32;
    localparam int AMT_W  = $clog2(XLEN);
    localparam int WAMT_W = $clog2(HALF);
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_W_SHL_IMM  = 4'd0,
        OP_W_SHR_IMM  = 4'd1,
        OP_W_SAR_IMM  = 4'd2,
        OP_W_SHL_REG  = 4'd3,
        OP_W_SHR_REG  = 4'd4,
        OP_W_SAR_REG  = 4'd5,
        OP_D_SHL_IMM  = 4'd6,
        OP_D_SHR_IMM  = 4'd7,
        OP_D_SAR_IMM  = 4'd8,
        OP_D_SHL_REG  = 4'd9,
        OP_D_SHR_REG  = 4'd10,
        OP_D_SAR_REG  = 4'd11,
        OP_D_SHL_HI   = 4'd12,
        OP_D_SHR_HI   = 4'd13,
        OP_D_SAR_HI   = 4'd14,
        OP_NONE       = 4'd15
    } shop_e;

    typedef struct packed {
        logic             valid;
        logic             word;
        logic             left;
        logic             arith;
        logic [AMT_W-1:0] amt;
    } shctl_t;

endpackage

// File: rtl/shift_unit_decode.sv
// Decoder: turns an operation code and the two amount sources into a
// control record (width, direction, fill kind, effective amount).
// Assumes IMM_W equals the word amount width, so imm + HALF never overflows.
module shift_unit_decode
    import shift_unit_pkg::*;
#(
    parameter int IMM_W = WAMT_W
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [AMT_W-1:0] reg_amt_i,
    output shctl_t           ctl_o
);

    logic [AMT_W-1:0] imm_z;
    logic [AMT_W-1:0] reg_word;
    logic [AMT_W-1:0] imm_hi;

    // Candidate amounts: zero-extended immediate, word-masked register, immediate plus half width
    assign imm_z    = AMT_W'(imm_i);
    assign reg_word = AMT_W'(reg_amt_i[WAMT_W-1:0]);
    assign imm_hi   = AMT_W'(HALF) + imm_z;

    // Operation table: one row per code, unused code leaves the record invalid
    always_comb begin
        ctl_o = '0;
        case (op_i)
            OP_W_SHL_IMM: ctl_o = '{valid: 1'b1, word: 1'b1, left: 1'b1, arith: 1'b0, amt: imm_z};
            OP_W_SHR_IMM: ctl_o = '{valid: 1'b1, word: 1'b1, left: 1'b0, arith: 1'b0, amt: imm_z};
            OP_W_SAR_IMM: ctl_o = '{valid: 1'b1, word: 1'b1, left: 1'b0, arith: 1'b1, amt: imm_z};
            OP_W_SHL_REG: ctl_o = '{valid: 1'b1, word: 1'b1, left: 1'b1, arith: 1'b0, amt: reg_word};
            OP_W_SHR_REG: ctl_o = '{valid: 1'b1, word: 1'b1, left: 1'b0, arith: 1'b0, amt: reg_word};
            OP_W_SAR_REG: ctl_o = '{valid: 1'b1, word: 1'b1, left: 1'b0, arith: 1'b1, amt: reg_word};
            OP_D_SHL_IMM: ctl_o = '{valid: 1'b1, word: 1'b0, left: 1'b1, arith: 1'b0, amt: imm_z};
            OP_D_SHR_IMM: ctl_o = '{valid: 1'b1, word: 1'b0, left: 1'b0, arith: 1'b0, amt: imm_z};
            OP_D_SAR_IMM: ctl_o = '{valid: 1'b1, word: 1'b0, left: 1'b0, arith: 1'b1, amt: imm_z};
            OP_D_SHL_REG: ctl_o = '{valid: 1'b1, word: 1'b0, left: 1'b1, arith: 1'b0, amt: reg_amt_i};
            OP_D_SHR_REG: ctl_o = '{valid: 1'b1, word: 1'b0, left: 1'b0, arith: 1'b0, amt: reg_amt_i};
            OP_D_SAR_REG: ctl_o = '{valid: 1'b1, word: 1'b0, left: 1'b0, arith: 1'b1, amt: reg_amt_i};
            OP_D_SHL_HI:  ctl_o = '{valid: 1'b1, word: 1'b0, left: 1'b1, arith: 1'b0, amt: imm_hi};
            OP_D_SHR_HI:  ctl_o = '{valid: 1'b1, word: 1'b0, left: 1'b0, arith: 1'b0, amt: imm_hi};
            OP_D_SAR_HI:  ctl_o = '{valid: 1'b1, word: 1'b0, left: 1'b0, arith: 1'b1, amt: imm_hi};
            default:      ctl_o = '0;
        endcase
    end

endmodule

// File: rtl/shift_unit_barrel.sv
// Barrel shifter: a logarithmic right shifter with a fill bit. Left shifts
// are obtained by reversing the bits before and after the shift.
// Assumes the caller drives fill_i low for left shifts.
module shift_unit_barrel #(
    parameter int W  = 64,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [AW-1:0] amt_i,
    input  logic          left_i,
    input  logic          fill_i,
    output logic [W-1:0]  data_o
);

    logic [W-1:0] pre;
    logic [W-1:0] stg [0:AW];

    // Input reversal for left shifts
    for (genvar i = 0; i < W; i++) begin : g_pre
        assign pre[i] = left_i ? data_i[W-1-i] : data_i[i];
    end

    assign stg[0] = pre;

    // One stage per amount bit, each shifting by a power of two
    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int S = 1 << k;
        assign stg[k+1] = amt_i[k] ? {{S{fill_i}}, stg[k][W-1:S]} : stg[k];
    end

    // Output reversal for left shifts
    for (genvar i = 0; i < W; i++) begin : g_post
        assign data_o[i] = left_i ? stg[AW][W-1-i] : stg[AW][i];
    end

endmodule

// File: rtl/shift_unit.sv
// Shift unit top: decodes the code, prepares the operand for word or
// doubleword width, runs one barrel, sign-extends word results and
// registers the outcome. Synchronous active-low reset clears the result.
module shift_unit
    import shift_unit_pkg::*;
#(
    parameter int IMM_W = WAMT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_i,
    input  logic [XLEN-1:0]  operand_i,
    input  logic [IMM_W-1:0] imm_sa_i,
    input  logic [AMT_W-1:0] reg_sa_i,
    output logic [XLEN-1:0]  result_o
);

    localparam int EXT_W = XLEN - HALF;

    shctl_t          ctl;
    logic            sign_bit;
    logic            fill;
    logic [XLEN-1:0] core_in;
    logic [XLEN-1:0] core_out;
    logic [XLEN-1:0] res_d;
    logic [XLEN-1:0] res_q;

    shift_unit_decode #(.IMM_W(IMM_W)) decode_i (
        .op_i      (op_i),
        .imm_i     (imm_sa_i),
        .reg_amt_i (reg_sa_i),
        .ctl_o     (ctl)
    );

    // Fill bit: sign of the active width for arithmetic shifts, else zero
    always_comb begin
        sign_bit = ctl.word ? operand_i[HALF-1] : operand_i[XLEN-1];
        fill     = ctl.arith & ~ctl.left & sign_bit;
    end

    // Operand preparation: word forms drop the upper half in favour of the fill
    assign core_in = ctl.word ? {{EXT_W{fill}}, operand_i[HALF-1:0]} : operand_i;

    shift_unit_barrel #(.W(XLEN), .AW(AMT_W)) barrel_i (
        .data_i (core_in),
        .amt_i  (ctl.amt),
        .left_i (ctl.left),
        .fill_i (fill),
        .data_o (core_out)
    );

    // Result formatting: zero for unused codes, sign-extend word results
    always_comb begin
        if (!ctl.valid) begin
            res_d = '0;
        end else if (ctl.word) begin
            res_d = {{EXT_W{core_out[HALF-1]}}, core_out[HALF-1:0]};
        end else begin
            res_d = core_out;
        end
    end

    // Result register with synchronous active-low clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign result_o = res_q;

endmodule

// File: rtl/shift_unit_chk.sv
// Checker: properties relating inputs at one edge to the registered result
// at the next. Armed one cycle after reset leaves so that the cleared result
// is never compared against the first post-reset inputs.
module shift_unit_chk
    import shift_unit_pkg::*;
#(
    parameter int IMM_W = WAMT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OP_W-1:0]  op_i,
    input logic [XLEN-1:0]  operand_i,
    input logic [IMM_W-1:0] imm_sa_i,
    input logic [AMT_W-1:0] reg_sa_i,
    input logic [XLEN-1:0]  result_o
);

    logic armed;

    // Arm flag: set after the first clock out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r1_word_sext: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(op_i) <= OP_W_SAR_REG) |-> (result_o[XLEN-1:HALF] == {(XLEN-HALF){result_o[HALF-1]}}));

    a_r2_shr_nonneg: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(op_i) == OP_W_SHR_IMM && $past(imm_sa_i) != '0) |-> (result_o[XLEN-1:HALF-1] == '0));

    a_r3_sar_sign: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(op_i) == OP_W_SAR_IMM) |-> (result_o[XLEN-1] == $past(operand_i[HALF-1])));

    a_r4_word_mask: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(op_i) == OP_W_SHL_REG && $past(reg_sa_i) == AMT_W'(HALF))
        |-> (result_o == {{(XLEN-HALF){$past(operand_i[HALF-1])}}, $past(operand_i[HALF-1:0])}));

    a_r6_hi_low_zero: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(op_i) == OP_D_SHL_HI) |-> (result_o[HALF-1:0] == '0));

    a_r7_dsar_sign: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(op_i) == OP_D_SAR_REG) |-> (result_o[XLEN-1] == $past(operand_i[XLEN-1])));

    a_r8_zero_pass: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(op_i) == OP_D_SHL_IMM && $past(imm_sa_i) == '0) |-> (result_o == $past(operand_i)));

    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(op_i) == OP_NONE) |-> (result_o == '0));

endmodule

bind shift_unit shift_unit_chk chk_i (.*);

// File: tb/shift_unit_tb_top.sv
`timescale 1ns/1ps
module shift_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [63:0] operand_i = 64'd0;
    logic [4:0]  imm_sa_i = 5'd0;
    logic [5:0]  reg_sa_i = 6'd0;
    logic [63:0] result_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    shift_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op_i),
        .operand_i (operand_i),
        .imm_sa_i  (imm_sa_i),
        .reg_sa_i  (reg_sa_i),
        .result_o  (result_o)
    );

    // Reference model written from the requirements
    function automatic logic [63:0] ref_model(input logic [3:0] op, input logic [63:0] a,
                                              input logic [4:0] imm, input logic [5:0] rsa);
        logic [31:0] w;
        logic [63:0] d;
        int s;
        w = 32'd0;
        d = 64'd0;
        if (op <= 4'd2) s = imm;
        else if (op <= 4'd5) s = rsa[4:0];
        else if (op <= 4'd8) s = imm;
        else if (op <= 4'd11) s = rsa;
        else s = 32 + imm;
        case (op)
            4'd0, 4'd3: w = a[31:0] << s;
            4'd1, 4'd4: w = a[31:0] >> s;
            4'd2, 4'd5: w = $unsigned($signed(a[31:0]) >>> s);
            4'd6, 4'd9, 4'd12:  d = a << s;
            4'd7, 4'd10, 4'd13: d = a >> s;
            4'd8, 4'd11, 4'd14: d = $unsigned($signed(a) >>> s);
            default: d = 64'd0;
        endcase
        if (op <= 4'd5) return {{32{w[31]}}, w};
        return d;
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd3: return "R1";
            4'd1, 4'd4: return "R2";
            4'd2, 4'd5: return "R3";
            4'd9, 4'd10, 4'd11: return "R5";
            4'd12, 4'd13, 4'd14: return "R6";
            4'd15: return "R9";
            default: return "R7";
        endcase
    endfunction

    task automatic compare(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one operation and check the registered result one edge later
    task automatic run(input string req, input logic [3:0] op, input logic [63:0] a,
                       input logic [4:0] imm, input logic [5:0] rsa, input logic [63:0] exp);
        @(negedge clk);
        op_i = op; operand_i = a; imm_sa_i = imm; reg_sa_i = rsa;
        @(negedge clk);
        compare(req, result_o, exp);
    endtask

    task automatic run_ref(input string req, input logic [3:0] op, input logic [63:0] a,
                           input logic [4:0] imm, input logic [5:0] rsa);
        run(req, op, a, imm, rsa, ref_model(op, a, imm, rsa));
    endtask

    task automatic t_reset();
        @(negedge clk);
        op_i = 4'd6; operand_i = 64'hDEAD_BEEF_0000_0001; imm_sa_i = 5'd3;
        @(negedge clk);
        compare("R10 reset clear", result_o, 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_word_left();
        run("R1 left into bit31", 4'd0, 64'hFFFF_FFFF_4000_0001, 5'd1, 6'd0, 64'hFFFF_FFFF_8000_0002);
        run("R1 upper ignored", 4'd0, 64'h1234_5678_0000_00FF, 5'd4, 6'd0, 64'h0000_0000_0000_0FF0);
    endtask

    task automatic t_word_shr();
        run("R2 zero amount negative", 4'd1, 64'h0000_0000_8000_0000, 5'd0, 6'd0, 64'hFFFF_FFFF_8000_0000);
        run("R2 one bit positive", 4'd1, 64'h0000_0000_8000_0000, 5'd1, 6'd0, 64'h0000_0000_4000_0000);
        run("R2 upper ignored", 4'd4, 64'hABCD_EF01_F000_0000, 5'd0, 6'd4, 64'h0000_0000_0F00_0000);
    endtask

    task automatic t_word_sar();
        run("R3 sign from bit31", 4'd2, 64'h1234_5678_8000_0000, 5'd4, 6'd0, 64'hFFFF_FFFF_F800_0000);
        run("R3 upper sign ignored", 4'd5, 64'hFFFF_FFFF_7000_0000, 5'd0, 6'd4, 64'h0000_0000_0700_0000);
    endtask

    task automatic t_word_mask();
        run("R4 bit5 ignored shift1", 4'd3, 64'h0000_0000_0000_0003, 5'd0, 6'h21, 64'h0000_0000_0000_0006);
        run("R4 amount 32 acts as 0", 4'd4, 64'h0000_0000_8000_0001, 5'd0, 6'h20, 64'hFFFF_FFFF_8000_0001);
    endtask

    task automatic t_dw_reg();
        run("R5 shift 63 left", 4'd9, 64'h0000_0000_0000_0001, 5'd0, 6'd63, 64'h8000_0000_0000_0000);
        run("R5 shift 40 right", 4'd10, 64'hFF00_0000_0000_0000, 5'd0, 6'd40, 64'h0000_0000_00FF_0000);
    endtask

    task automatic t_dw_hi();
        run("R6 +32 with imm 0", 4'd12, 64'h0000_0000_1234_5678, 5'd0, 6'd0, 64'h1234_5678_0000_0000);
        run("R6 +32 with imm 31", 4'd14, 64'h8000_0000_0000_0000, 5'd31, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        run("R6 logical +32 imm 31", 4'd13, 64'h8000_0000_0000_0000, 5'd31, 6'd0, 64'h0000_0000_0000_0001);
    endtask

    task automatic t_dw_right();
        run("R7 arith fills bit63", 4'd8, 64'h8000_0000_0000_0000, 5'd4, 6'd0, 64'hF800_0000_0000_0000);
        run("R7 logical fills zero", 4'd7, 64'h8000_0000_0000_0000, 5'd4, 6'd0, 64'h0800_0000_0000_0000);
    endtask

    task automatic t_zero_amount();
        run("R8 dw pass-through", 4'd6, 64'hCAFE_F00D_1234_5678, 5'd0, 6'd0, 64'hCAFE_F00D_1234_5678);
        run("R8 word pass-through", 4'd0, 64'hCAFE_F00D_9234_5678, 5'd0, 6'd0, 64'hFFFF_FFFF_9234_5678);
        run("R8 dw reg zero", 4'd11, 64'h8765_4321_0FED_CBA9, 5'd0, 6'd0, 64'h8765_4321_0FED_CBA9);
    endtask

    task automatic t_unused();
        run("R9 unused code zero", 4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 5'd7, 6'd7, 64'd0);
    endtask

    task automatic t_latency();
        run("R10 first value", 4'd6, 64'h0000_0000_0000_0011, 5'd1, 6'd0, 64'h0000_0000_0000_0022);
        @(negedge clk);
        op_i = 4'd6; operand_i = 64'h0000_0000_0000_0001; imm_sa_i = 5'd8;
        #1;
        compare("R10 holds before edge", result_o, 64'h0000_0000_0000_0022);
        @(negedge clk);
        compare("R10 updates after edge", result_o, 64'h0000_0000_0000_0100);
    endtask

    task automatic t_sweep();
        logic [63:0] pats [3];
        pats[0] = 64'h8123_4567_89AB_CDEF;
        pats[1] = 64'h7FED_CBA9_7654_3210;
        pats[2] = 64'h0000_0001_FFFF_FFFE;
        for (int p = 0; p < 3; p++) begin
            for (int op = 0; op < 16; op++) begin
                for (int s = 0; s < 64; s++) begin
                    run_ref(tag_of(4'(op)), 4'(op), pats[p], 5'(s), 6'(s));
                end
            end
        end
    endtask

    initial begin
        t_reset();
        t_word_left();
        t_word_shr();
        t_word_sar();
        t_word_mask();
        t_dw_reg();
        t_dw_hi();
        t_dw_right();
        t_zero_amount();
        t_unused();
        t_latency();
        t_sweep();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule